// File: doc/BRIEF.md
# Flag-Generating Arithmetic and Logic Unit

This block is the purely combinational arithmetic and logic stage of an 8-bit accumulator datapath. The same unit also serves 16-bit operations on a paired accumulator. It takes two operands, the current carry flag and a 5-bit operation code. A width select chooses between byte and word mode. It returns the result, a write-back indication and the proposed next values of five condition flags. Each flag has its own update enable. When an enable is low, the surrounding register logic keeps that flag's old value, so an operation can leave a flag untouched.

The operations are:
- Arithmetic: add, add with carry, subtract, subtract with borrow, negate, compare, increment and decrement.
- Logic: AND, OR, XOR, bit test, complement, clear and test.
- Shifts and rotates: logical and arithmetic right shift, left shift, and left and right rotate through the carry.

Compare, test and bit test only set the flags and request no write-back. Flags are computed at the selected width. In byte mode the upper operand bytes are ignored and the upper result byte reads zero.

Top module: `ccalu_core`

## Requirements
- R1: The operation codes are 0 add, 1 add-with-carry, 2 subtract, 3 subtract-with-borrow, 4 negate, 5 compare, 6 AND, 7 OR, 8 XOR, 9 complement, 10 clear, 11 increment, 12 decrement, 13 test, 14 bit test, 15 logical right shift, 16 arithmetic right shift, 17 left shift, 18 rotate left, 19 rotate right.
- R1 (continued): Codes 20 to 31 assert no flag enable and no write-back. With `wide_i` low, operand bits 15:8 have no effect and `res_o[15:8]` is zero.
- R2: The flag bus is ordered H at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0.
- R2 (continued): N is result bit 7 in byte mode and bit 15 in word mode. Z is 1 exactly when the result at the selected width is zero.
- R3: Add and add-with-carry (carry-in from `cin_i`) produce the sum. C is the carry out of the sign bit, and V is the XOR of the carries into and out of the sign bit. H is the carry out of bit 3 and is enabled only in byte mode.
- R4: Subtract, subtract-with-borrow (borrow-in from `cin_i`), negate (zero minus operand A) and compare produce the difference. C is the unsigned borrow, and V is two's-complement overflow.
- R5: `wb_o` is 0 for compare, test and bit test. It is 1 for every other listed code.
- R6: AND, OR, XOR and bit test drive V to 0 with its enable set, and leave C disabled.
- R7: Complement returns the inverted operand with V=0 and C=1. Test returns operand A with V=0 and C=0.
- R8: Clear returns zero with N=0, Z=1, V=0, C=0, all four enabled.
- R9: Increment and decrement update N, Z and V, and leave C disabled.
- R10: The logical right shift fills the MSB with 0. The arithmetic right shift copies the MSB. The left shift fills the LSB with 0. Each shift puts the bit shifted out into C.
- R11: The rotates move `cin_i` into the vacated end and put the bit leaving the other end into C.
- R12: For every shift and rotate, V equals N XOR C of the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| wide_i | input | 1 | 1 selects 16-bit operation, 0 selects 8-bit |
| opa_i | input | 16 | First operand (the accumulator) |
| opb_i | input | 16 | Second operand (the memory operand) |
| cin_i | input | 1 | Current carry flag |
| res_o | output | 16 | Operation result |
| wb_o | output | 1 | Result should be written back |
| flag_o | output | 5 | Proposed next flags {H,N,Z,V,C} |
| flag_en_o | output | 5 | Per-flag update enables, same bit order |

## Verification
The bench targets the sign-bit boundaries:
- 0x7F plus one and 0x80 minus one must raise V. A unit that took V from the carry out alone would miss both.
- Negating 0x80 must return 0x80 with V set, and negating zero must clear C. A wrong borrow sense inverts C on every subtract.

Width handling is exercised with garbage in the upper operand bytes, and with word-mode cases whose result only differs at bit 15. A unit that used the wrong sign position would report a wrong N or a nonzero high byte. Rotate cases check that the old carry enters the correct end. A unit that treated rotates as shifts would drop that bit. Logic, increment and decrement cases check that C stays disabled. A unit that enabled it would silently corrupt a carry chain.

// File: rtl/ccalu_pkg.sv
package ccalu_pkg;

    parameter int BYTE_W = 8;
    parameter int WORD_W = 2 * BYTE_W;
    parameter int OP_W   = 5;
    localparam int N_WIDTHS = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
        OP_NEG = 5'd4,  OP_CMP = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
        OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_CLR = 5'd10, OP_INC = 5'd11,
        OP_DEC = 5'd12, OP_TST = 5'd13, OP_BIT = 5'd14, OP_LSR = 5'd15,
        OP_ASR = 5'd16, OP_ASL = 5'd17, OP_ROL = 5'd18, OP_ROR = 5'd19
    } alu_op_e;

    typedef enum logic [1:0] {
        CLS_ARITH, CLS_LOGIC, CLS_SHIFT, CLS_NONE
    } op_class_e;

    typedef struct packed {
        logic h;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic              c;
        logic              v;
        logic              h;
    } unit_res_t;

    function automatic logic [WORD_W-1:0] width_mask(input logic wide);
        return wide ? {WORD_W{1'b1}} : WORD_W'({BYTE_W{1'b1}});
    endfunction

    function automatic op_class_e op_class(input alu_op_e op);
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG, OP_CMP,
            OP_INC, OP_DEC:                          return CLS_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_COM, OP_CLR,
            OP_TST, OP_BIT:                          return CLS_LOGIC;
            OP_LSR, OP_ASR, OP_ASL, OP_ROL, OP_ROR:  return CLS_SHIFT;
            default:                                 return CLS_NONE;
        endcase
    endfunction

    function automatic logic writes_back(input alu_op_e op);
        case (op_class(op))
            CLS_NONE: return 1'b0;
            default:  return !(op == OP_CMP || op == OP_TST || op == OP_BIT);
        endcase
    endfunction

    function automatic ccr_t flag_enables(input alu_op_e op, input logic wide);
        ccr_t e;
        e = '0;
        case (op_class(op))
            CLS_ARITH: begin
                e.n = 1'b1;
                e.z = 1'b1;
                e.v = 1'b1;
                e.c = !(op == OP_INC || op == OP_DEC);
                e.h = (op == OP_ADD || op == OP_ADC) && !wide;
            end
            CLS_LOGIC: begin
                e.n = 1'b1;
                e.z = 1'b1;
                e.v = 1'b1;
                e.c = (op == OP_COM || op == OP_CLR || op == OP_TST);
            end
            CLS_SHIFT: begin
                e.n = 1'b1;
                e.z = 1'b1;
                e.v = 1'b1;
                e.c = 1'b1;
            end
            default: e = '0;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/ccalu_adder.sv
module ccalu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         ci,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         cmsb,
    output logic         c4
);
    logic [W:0] full;

    always_comb begin
        full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    end

    assign sum  = full[W-1:0];
    assign cout = full[W];
    // carry into a bit position recovered from sum and operand bits there
    assign cmsb = full[W-1] ^ x[W-1] ^ y[W-1];
    assign c4   = full[4] ^ x[4] ^ y[4];

endmodule

// File: rtl/ccalu_addsub.sv
module ccalu_addsub
    import ccalu_pkg::*;
(
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    input  logic              cin,
    output unit_res_t         out
);
    logic [WORD_W-1:0] x, y;
    logic              ci, is_sub;

    logic [WORD_W-1:0] sum_g [N_WIDTHS];
    logic              co_g  [N_WIDTHS];
    logic              cm_g  [N_WIDTHS];
    logic              c4_g  [N_WIDTHS];

    always_comb begin
        x      = a;
        y      = b;
        ci     = 1'b0;
        is_sub = 1'b0;
        case (op)
            OP_ADC: ci = cin;
            OP_SUB, OP_CMP: begin
                y = ~b;  ci = 1'b1;  is_sub = 1'b1;
            end
            OP_SBC: begin
                y = ~b;  ci = ~cin;  is_sub = 1'b1;
            end
            OP_NEG: begin
                x = '0;  y = ~a;  ci = 1'b1;  is_sub = 1'b1;
            end
            OP_INC: begin
                y = '0;  ci = 1'b1;
            end
            OP_DEC: begin
                y = '1;  ci = 1'b0;
            end
            default: ;
        endcase
    end

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_width
        localparam int W = (g == 0) ? BYTE_W : WORD_W;
        logic [W-1:0] s;
        ccalu_adder #(.W(W)) u_add (
            .x    (x[W-1:0]),
            .y    (y[W-1:0]),
            .ci   (ci),
            .sum  (s),
            .cout (co_g[g]),
            .cmsb (cm_g[g]),
            .c4   (c4_g[g])
        );
        assign sum_g[g] = WORD_W'(s);
    end

    always_comb begin
        out.res = sum_g[wide];
        out.c   = co_g[wide] ^ is_sub;
        out.v   = co_g[wide] ^ cm_g[wide];
        out.h   = c4_g[wide] & ~wide;
    end

    // subtracting a value from itself never borrows and gives zero
    always_comb begin
        if ((op == OP_SUB || op == OP_CMP) && a == b) begin
            assert_self_sub_R4: assert (out.res == '0 && !out.c)
                else $error("self-subtract gave nonzero or borrow");
        end
    end

endmodule

// File: rtl/ccalu_bitwise.sv
module ccalu_bitwise
    import ccalu_pkg::*;
(
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output unit_res_t         out
);
    logic [WORD_W-1:0] raw;

    always_comb begin
        case (op)
            OP_AND, OP_BIT: raw = a & b;
            OP_OR:          raw = a | b;
            OP_XOR:         raw = a ^ b;
            OP_COM:         raw = ~a;
            OP_CLR:         raw = '0;
            default:        raw = a;
        endcase
        out.res = raw & width_mask(wide);
        out.c   = (op == OP_COM);
        out.v   = 1'b0;
        out.h   = 1'b0;
    end

endmodule

// File: rtl/ccalu_shifter.sv
module ccalu_shifter
    import ccalu_pkg::*;
(
    input  alu_op_e           op,
    input  logic              wide,
    input  logic [WORD_W-1:0] a,
    input  logic              cin,
    output unit_res_t         out
);
    localparam int IDX_W = $clog2(WORD_W);

    logic [WORD_W-1:0] am, top_bit, raw;
    logic [IDX_W-1:0]  msb;
    logic              lsb_out, msb_out;

    always_comb begin
        msb     = wide ? IDX_W'(WORD_W - 1) : IDX_W'(BYTE_W - 1);
        am      = a & width_mask(wide);
        top_bit = WORD_W'(1) << msb;
        lsb_out = am[0];
        msb_out = am[msb];
        case (op)
            OP_LSR: raw = am >> 1;
            OP_ASR: raw = (am >> 1) | (msb_out ? top_bit : '0);
            OP_ASL: raw = am << 1;
            OP_ROL: raw = (am << 1) | WORD_W'(cin);
            OP_ROR: raw = (am >> 1) | (cin ? top_bit : '0);
            default: raw = am;
        endcase
        out.res = raw & width_mask(wide);
        out.c   = (op == OP_ASL || op == OP_ROL) ? msb_out : lsb_out;
        out.v   = out.res[msb] ^ out.c;
        out.h   = 1'b0;
    end

    // a rotate neither creates nor loses a one across {value, carry}
    always_comb begin
        if (op == OP_ROL || op == OP_ROR) begin
            assert_rot_conserve_R11: assert
                ($countones({out.res, out.c}) == $countones({am, cin}))
                else $error("rotate changed the number of set bits");
        end
    end

endmodule

// File: rtl/ccalu_core.sv
module ccalu_core
    import ccalu_pkg::*;
(
    input  logic [4:0]  op_i,
    input  logic        wide_i,
    input  logic [15:0] opa_i,
    input  logic [15:0] opb_i,
    input  logic        cin_i,
    output logic [15:0] res_o,
    output logic        wb_o,
    output logic [4:0]  flag_o,
    output logic [4:0]  flag_en_o
);
    alu_op_e   op;
    op_class_e cls;
    unit_res_t u_arith, u_logic, u_shift, sel;
    logic [WORD_W-1:0] res_m;
    ccr_t flags, enables;

    assign op  = alu_op_e'(op_i);
    assign cls = op_class(op);

    ccalu_addsub u_addsub (
        .op   (op),
        .wide (wide_i),
        .a    (opa_i),
        .b    (opb_i),
        .cin  (cin_i),
        .out  (u_arith)
    );

    ccalu_bitwise u_bitwise (
        .op   (op),
        .wide (wide_i),
        .a    (opa_i),
        .b    (opb_i),
        .out  (u_logic)
    );

    ccalu_shifter u_shifter (
        .op   (op),
        .wide (wide_i),
        .a    (opa_i),
        .cin  (cin_i),
        .out  (u_shift)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: sel = u_arith;
            CLS_SHIFT: sel = u_shift;
            default:   sel = u_logic;
        endcase
        res_m   = sel.res & width_mask(wide_i);
        flags.h = sel.h;
        flags.n = wide_i ? res_m[WORD_W-1] : res_m[BYTE_W-1];
        flags.z = (res_m == '0);
        flags.v = sel.v;
        flags.c = sel.c;
        enables = flag_enables(op, wide_i);
    end

    assign res_o     = res_m;
    assign flag_o    = flags;
    assign flag_en_o = enables;
    assign wb_o      = writes_back(op);

    always_comb begin
        if (!wide_i) begin
            assert_narrow_upper_R1: assert (res_o[15:8] == 8'h00)
                else $error("byte-mode result has upper bits set");
        end
        if (op == OP_CLR) begin
            assert_clear_flags_R8: assert (res_o == '0 && flag_o[3:0] == 4'b0100
                                           && flag_en_o[3:0] == 4'b1111)
                else $error("clear produced wrong flags");
        end
        if (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_BIT) begin
            assert_logic_vc_R6: assert (!flag_o[1] && flag_en_o[1] && !flag_en_o[0])
                else $error("logic op touched C or left V set");
        end
        if (op == OP_INC || op == OP_DEC) begin
            assert_keep_carry_R9: assert (!flag_en_o[0])
                else $error("increment/decrement enabled C");
        end
        if (op == OP_CMP || op == OP_TST || op == OP_BIT) begin
            assert_no_writeback_R5: assert (!wb_o)
                else $error("flag-only op requested write-back");
        end
    end

endmodule

// File: tb/ccalu_core_tb_top.sv
module ccalu_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic [15:0] opa_i = '0, opb_i = '0;
    logic        cin_i = 1'b0;
    logic [15:0] res_o;
    logic        wb_o;
    logic [4:0]  flag_o, flag_en_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    ccalu_core dut_i (
        .op_i (op_i), .wide_i (wide_i), .opa_i (opa_i), .opb_i (opb_i),
        .cin_i (cin_i), .res_o (res_o), .wb_o (wb_o),
        .flag_o (flag_o), .flag_en_o (flag_en_o)
    );

    // {op, wide, a, b, cin, expected result, expected flags HNZVC}
    localparam int NV = 33;
    localparam logic [59:0] VEC [NV] = '{
        {5'd0,  1'b0, 16'h003A, 16'h0048, 1'b0, 16'h0082, 5'b11010},
        {5'd0,  1'b0, 16'h00FF, 16'h0001, 1'b0, 16'h0000, 5'b10101},
        {5'd1,  1'b0, 16'h0080, 16'h0080, 1'b1, 16'h0001, 5'b00011},
        {5'd0,  1'b1, 16'h7FFF, 16'h0001, 1'b0, 16'h8000, 5'b01010},
        {5'd2,  1'b0, 16'h0010, 16'h0020, 1'b0, 16'h00F0, 5'b01001},
        {5'd2,  1'b0, 16'h0080, 16'h0001, 1'b0, 16'h007F, 5'b00010},
        {5'd3,  1'b0, 16'h0000, 16'h0000, 1'b1, 16'h00FF, 5'b01001},
        {5'd2,  1'b1, 16'h1234, 16'h1234, 1'b0, 16'h0000, 5'b00100},
        {5'd4,  1'b0, 16'h0001, 16'h0000, 1'b0, 16'h00FF, 5'b01001},
        {5'd4,  1'b0, 16'h0080, 16'h0000, 1'b0, 16'h0080, 5'b01011},
        {5'd4,  1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 5'b00100},
        {5'd5,  1'b0, 16'h0005, 16'h0007, 1'b0, 16'h00FE, 5'b01001},
        {5'd6,  1'b0, 16'h00F0, 16'h003C, 1'b1, 16'h0030, 5'b00000},
        {5'd7,  1'b1, 16'h8000, 16'h0001, 1'b0, 16'h8001, 5'b01000},
        {5'd8,  1'b0, 16'h005A, 16'h005A, 1'b0, 16'h0000, 5'b00100},
        {5'd9,  1'b0, 16'h000F, 16'h0000, 1'b0, 16'h00F0, 5'b01001},
        {5'd10, 1'b1, 16'h1234, 16'h5678, 1'b1, 16'h0000, 5'b00100},
        {5'd11, 1'b0, 16'h007F, 16'h0000, 1'b0, 16'h0080, 5'b01010},
        {5'd12, 1'b0, 16'h0080, 16'h0000, 1'b1, 16'h007F, 5'b00010},
        {5'd11, 1'b1, 16'hFFFF, 16'h0000, 1'b0, 16'h0000, 5'b00100},
        {5'd13, 1'b0, 16'h0080, 16'h0000, 1'b1, 16'h0080, 5'b01000},
        {5'd14, 1'b0, 16'h00AA, 16'h0055, 1'b0, 16'h0000, 5'b00100},
        {5'd15, 1'b0, 16'h0081, 16'h0000, 1'b0, 16'h0040, 5'b00011},
        {5'd16, 1'b0, 16'h0081, 16'h0000, 1'b0, 16'h00C0, 5'b01001},
        {5'd17, 1'b0, 16'h0081, 16'h0000, 1'b0, 16'h0002, 5'b00011},
        {5'd18, 1'b0, 16'h0040, 16'h0000, 1'b1, 16'h0081, 5'b01010},
        {5'd19, 1'b0, 16'h0002, 16'h0000, 1'b1, 16'h0081, 5'b01010},
        {5'd17, 1'b1, 16'h4000, 16'h0000, 1'b0, 16'h8000, 5'b01010},
        {5'd19, 1'b1, 16'h0001, 16'h0000, 1'b0, 16'h0000, 5'b00111},
        {5'd16, 1'b1, 16'h8000, 16'h0000, 1'b0, 16'hC000, 5'b01010},
        {5'd0,  1'b0, 16'hAB01, 16'hCD02, 1'b0, 16'h0003, 5'b00000},
        {5'd1,  1'b0, 16'h000F, 16'h0000, 1'b0, 16'h000F, 5'b00000},
        {5'd9,  1'b1, 16'h00FF, 16'h0000, 1'b0, 16'hFF00, 5'b01001}
    };

    function automatic logic [4:0] exp_en(input logic [4:0] op, input logic wide);
        case (op)
            5'd0, 5'd1:                    return {~wide, 4'b1111};
            5'd2, 5'd3, 5'd4, 5'd5:        return 5'b01111;
            5'd6, 5'd7, 5'd8, 5'd14:       return 5'b01110;
            5'd9, 5'd10, 5'd13:            return 5'b01111;
            5'd11, 5'd12:                  return 5'b01110;
            5'd15, 5'd16, 5'd17, 5'd18, 5'd19: return 5'b01111;
            default:                       return 5'b00000;
        endcase
    endfunction

    function automatic logic exp_wb(input logic [4:0] op);
        return (op < 5'd20) && op != 5'd5 && op != 5'd13 && op != 5'd14;
    endfunction

    function automatic string req_of(input logic [4:0] op);
        case (op)
            5'd0, 5'd1:               return "R3";
            5'd2, 5'd3, 5'd4, 5'd5:   return "R4";
            5'd6, 5'd7, 5'd8, 5'd14:  return "R6";
            5'd9, 5'd13:              return "R7";
            5'd10:                    return "R8";
            5'd11, 5'd12:             return "R9";
            5'd15, 5'd16, 5'd17:      return "R10";
            5'd18, 5'd19:             return "R11";
            default:                  return "R1";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] op, input logic wide,
                         input logic [15:0] a, input logic [15:0] b, input logic c);
        @(negedge clk);
        op_i = op; wide_i = wide; opa_i = a; opb_i = b; cin_i = c;
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // idle inputs: 0 + 0 in byte mode gives zero with Z set (R2)
        apply(5'd0, 1'b0, 16'h0000, 16'h0000, 1'b0);
        chk("R2", "idle result", res_o, 16'h0000);
        chk("R2", "idle flags", {11'b0, flag_o & flag_en_o}, {11'b0, 5'b00100});

        for (int i = 0; i < NV; i++) begin
            logic [4:0]  v_op;
            logic        v_w;
            logic [15:0] v_a, v_b, v_r;
            logic        v_c;
            logic [4:0]  v_f, m;
            string       rq, rqf;
            {v_op, v_w, v_a, v_b, v_c, v_r, v_f} = VEC[i];
            apply(v_op, v_w, v_a, v_b, v_c);
            m   = exp_en(v_op, v_w);
            rq  = req_of(v_op);
            rqf = (v_op >= 5'd15) ? "R12" : rq;
            chk(rq,  $sformatf("vec%0d result", i), res_o, v_r);
            chk(rqf, $sformatf("vec%0d flags", i),
                {11'b0, flag_o & m}, {11'b0, v_f & m});
            chk("R2", $sformatf("vec%0d enables", i), {11'b0, flag_en_o}, {11'b0, m});
            chk("R5", $sformatf("vec%0d writeback", i), {15'b0, wb_o}, {15'b0, exp_wb(v_op)});
        end

        // write-back and enables across the whole code space, incl. unused codes (R1, R5)
        for (int k = 0; k < 32; k++) begin
            apply(5'(k), 1'b1, 16'h1111, 16'h2222, 1'b0);
            chk("R5", $sformatf("code%0d writeback", k), {15'b0, wb_o}, {15'b0, exp_wb(5'(k))});
            if (k >= 20)
                chk("R1", $sformatf("code%0d enables", k), {11'b0, flag_en_o}, 16'h0000);
        end

        // byte mode: upper operand bits must not reach the result (R1)
        apply(5'd8, 1'b0, 16'hFF00, 16'h0F00, 1'b0);
        chk("R1", "narrow xor upper", res_o, 16'h0000);
        chk("R1", "narrow xor zero", {15'b0, flag_o[2]}, 16'h0001);

        // word-mode H must be disabled even with a nibble carry (R3)
        apply(5'd0, 1'b1, 16'h000F, 16'h0001, 1'b0);
        chk("R3", "word add H enable", {15'b0, flag_en_o[4]}, 16'h0000);
        chk("R3", "word add result", res_o, 16'h0010);

        finish_run();
    end

endmodule